// File: doc/BRIEF.md
# Boundary-Scan Data Register with Mixed Pin Cells

This block is the boundary-scan data register that sits between a chip's core logic and its pads. An external test access port controller drives it through plain strobes: capture, shift and update, plus a test-mode select. Serial data enters at `tdi`, and the lowest cell appears at `tdo`. A parameter table gives each pad one of four kinds. Each kind owns a fixed group of consecutive cells:

| Kind | Code | Cells |
|------|------|-------|
| Input-only | 0 | one input cell |
| Always-driven output | 1 | one output cell |
| Tri-statable output | 2 | enable cell, then output cell |
| Bidirectional | 3 | enable cell, output cell, input cell |

In normal mode the core's drive value and high-impedance request pass straight to the pads. In test mode the pads follow update latches. The update latches change only on an update strobe, so pad values stay put while data shifts.

The chain length is derived from the table. Pin 0's cells take the lowest indices, and cell 0 is the cell nearest `tdo`. The default table describes 192 pads with 246 cells. All strobes act on the rising edge of `tck`. The strobes are level-qualified control pins, so the serial path has no back-pressure: one bit moves per clock in which the shift strobe is high.

Top module: `bscan_register`

## Requirements
- R1: An input-only pad (kind code 0) owns one cell, which captures `pin_in`. Its `pad_out` is always 0 and its `pad_hiz` is always 1, in both modes.
- R2: An always-driven output pad (code 1) owns one output cell. Its `pad_hiz` is always 0 and `core_hiz` has no effect on it.
- R3: A tri-statable output pad (code 2) owns two cells: the enable cell at the lower index, then the output cell. An enable value of 1 gives `pad_hiz`=1, and an output value of 1 gives `pad_out`=1.
- R4: A bidirectional pad (code 3) owns three consecutive cells in ascending order: enable, output, input. The input cell captures `pin_in`.
- R5: With `test_mode`=0, `pad_out` equals `core_out` and `pad_hiz` equals `core_hiz` on every pad able to drive or float, whatever the register holds.
- R6: With `test_mode`=1, pads follow the update latches. Those latches load from the shift stages only in a cycle with `update_dr`=1, so pads change only on the edge after such a cycle.
- R7: On each edge with `shift_dr`=1 and `capture_dr`=0, every stage takes the value of its higher neighbour. The top cell takes `tdi`. `tdo` always shows cell 0.
- R8: On an edge with `capture_dr`=1, every stage loads its cell's value in parallel. Input cells load `pin_in`, output cells load `core_out`, and enable cells load `core_hiz`. Capture takes priority over a simultaneous shift.
- R9: An update in the same cycle as a capture or a shift latches the stage contents from before that edge.
- R10: While `trst_n`=0, all stages and output and input update latches are 0. Enable update latches are 1, so every tri-statable pad floats in test mode.
- R11: The cell count is the sum over pads of 1, 1, 2 or 3 cells per kind. The default 192-pad table yields 246 cells, so a marker entering at `tdi` appears at `tdo` after exactly that many shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test-logic reset |
| test_mode | input | 1 | 1 = pads driven from update latches |
| capture_dr | input | 1 | Parallel-load strobe |
| shift_dr | input | 1 | Serial-shift strobe |
| update_dr | input | 1 | Update-latch strobe |
| tdi | input | 1 | Serial data into the highest cell |
| tdo | output | 1 | Serial data from cell 0 |
| pin_in | input | NUM_PINS | Level seen at each pad |
| core_out | input | NUM_PINS | Core drive value per pad |
| core_hiz | input | NUM_PINS | Core high-impedance request per pad (1 = float) |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_hiz | output | NUM_PINS | 1 = pad in high impedance |

## Verification
Two of the block's functions can fall in the same cycle: the update latch may load in the same cycle as the stages are overwritten by a capture or a shift. The bench fills the chain with known bits, then raises `update_dr` together with `capture_dr` in one cycle and together with `shift_dr` in another, while core and pad inputs change at random. A behavioural per-cell model compares `tdo` and every pad on every clock. After such an edge, the pads must show the bits that were in the chain before that edge, not the freshly captured or shifted ones.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    PIN_IN     = 2'd0,
    PIN_OUT    = 2'd1,
    PIN_OUT_TS = 2'd2,
    PIN_BIDIR  = 2'd3
  } pin_kind_e;

  localparam int MAX_PINS = 512;

  // cells owned by one pad of the given kind
  function automatic int cells_for(pin_kind_e k);
    case (k)
      PIN_IN:     return 1;
      PIN_OUT:    return 1;
      PIN_OUT_TS: return 2;
      default:    return 3;
    endcase
  endfunction

  // default pad table: 24 bidirectional, 6 tri-statable, rest alternate in/out
  function automatic logic [2*MAX_PINS-1:0] demo_table(int np);
    logic [2*MAX_PINS-1:0] t;
    t = '0;
    for (int p = 0; p < np; p++) begin
      if (p % 8 == 7)       t[2*p +: 2] = PIN_BIDIR;
      else if (p % 32 == 3) t[2*p +: 2] = PIN_OUT_TS;
      else if (p % 2 == 0)  t[2*p +: 2] = PIN_IN;
      else                  t[2*p +: 2] = PIN_OUT;
    end
    return t;
  endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
  parameter logic UPD_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic cap_d,
  input  logic ser_d,
  output logic stage_q,
  output logic upd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      upd_q   <= UPD_RST;
    end else begin
      if (capture)    stage_q <= cap_d;
      else if (shift) stage_q <= ser_d;
      if (update)     upd_q   <= stage_q;
    end
  end

endmodule

// File: rtl/bsr_pin.sv
module bsr_pin
  import bsr_pkg::*;
#(
  parameter pin_kind_e KIND = PIN_IN,
  localparam int NC = cells_for(KIND)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          shift,
  input  logic          update,
  input  logic          test_mode,
  input  logic [NC-1:0] ser_d,
  output logic [NC-1:0] stage_q,
  input  logic          pin_lvl,
  input  logic          core_o,
  input  logic          core_z,
  output logic          pad_o,
  output logic          pad_z
);

  logic [NC-1:0] cap_d;
  logic [NC-1:0] upd_q;

  // local cell 0 is the enable cell for kinds that can float
  localparam bit HAS_EN = (KIND == PIN_OUT_TS) || (KIND == PIN_BIDIR);

  for (genvar c = 0; c < NC; c++) begin : g_cell
    bsr_cell #(.UPD_RST(HAS_EN && (c == 0))) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .shift   (shift),
      .update  (update),
      .cap_d   (cap_d[c]),
      .ser_d   (ser_d[c]),
      .stage_q (stage_q[c]),
      .upd_q   (upd_q[c])
    );
  end

  if (KIND == PIN_IN) begin : g_in
    logic unused_ok;
    assign unused_ok = ^{core_o, core_z, upd_q, test_mode};
    assign cap_d = pin_lvl;
    assign pad_o = 1'b0;
    assign pad_z = 1'b1;
  end else if (KIND == PIN_OUT) begin : g_out
    logic unused_ok;
    assign unused_ok = ^{pin_lvl, core_z};
    assign cap_d = core_o;
    assign pad_o = test_mode ? upd_q[0] : core_o;
    assign pad_z = 1'b0;
  end else if (KIND == PIN_OUT_TS) begin : g_out_ts
    logic unused_ok;
    assign unused_ok = pin_lvl;
    assign cap_d = {core_o, core_z};
    assign pad_z = test_mode ? upd_q[0] : core_z;
    assign pad_o = test_mode ? upd_q[1] : core_o;
  end else begin : g_bidir
    assign cap_d = {pin_lvl, core_o, core_z};
    assign pad_z = test_mode ? upd_q[0] : core_z;
    assign pad_o = test_mode ? upd_q[1] : core_o;
  end

endmodule

// File: rtl/bscan_register.sv
module bscan_register
  import bsr_pkg::*;
#(
  parameter int NUM_PINS = 192,
  parameter logic [2*NUM_PINS-1:0] PIN_TYPES = (2*NUM_PINS)'(demo_table(NUM_PINS))
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                test_mode,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_hiz,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_hiz
);

  function automatic pin_kind_e kind_of(int p);
    return pin_kind_e'(PIN_TYPES[2*p +: 2]);
  endfunction

  // index of a pad's first cell: cells of all lower pads
  function automatic int base_of(int p);
    int s;
    s = 0;
    for (int i = 0; i < p; i++) s += cells_for(kind_of(i));
    return s;
  endfunction

  localparam int NUM_CELLS = base_of(NUM_PINS);

  logic [NUM_CELLS-1:0] stage_q;
  logic [NUM_CELLS-1:0] ser_d;

  assign ser_d = {tdi, stage_q[NUM_CELLS-1:1]};
  assign tdo   = stage_q[0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam pin_kind_e K = kind_of(p);
    localparam int B = base_of(p);
    localparam int N = cells_for(K);
    bsr_pin #(.KIND(K)) u_pin (
      .clk       (tck),
      .rst_n     (trst_n),
      .capture   (capture_dr),
      .shift     (shift_dr),
      .update    (update_dr),
      .test_mode (test_mode),
      .ser_d     (ser_d[B +: N]),
      .stage_q   (stage_q[B +: N]),
      .pin_lvl   (pin_in[p]),
      .core_o    (core_out[p]),
      .core_z    (core_hiz[p]),
      .pad_o     (pad_out[p]),
      .pad_z     (pad_hiz[p])
    );
  end

endmodule

// File: rtl/bscan_register_chk.sv
module bscan_register_chk #(
  parameter int NUM_PINS = 192,
  parameter logic [2*NUM_PINS-1:0] PIN_TYPES = '0,
  parameter int NUM_CELLS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 test_mode,
  input logic                 capture,
  input logic                 shift,
  input logic                 update,
  input logic                 tdo,
  input logic [NUM_CELLS-1:0] stage_q,
  input logic [NUM_PINS-1:0]  core_out,
  input logic [NUM_PINS-1:0]  core_hiz,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_PINS-1:0]  pad_hiz
);

  function automatic logic [NUM_PINS-1:0] mask_of(int lo, int hi);
    logic [NUM_PINS-1:0] m;
    for (int p = 0; p < NUM_PINS; p++)
      m[p] = (int'(PIN_TYPES[2*p +: 2]) >= lo) && (int'(PIN_TYPES[2*p +: 2]) <= hi);
    return m;
  endfunction

  localparam logic [NUM_PINS-1:0] IN_M  = mask_of(0, 0);
  localparam logic [NUM_PINS-1:0] OUT_M = mask_of(1, 1);
  localparam logic [NUM_PINS-1:0] DRV_M = mask_of(1, 3);
  localparam logic [NUM_PINS-1:0] TS_M  = mask_of(2, 3);

  AST_INPUT_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & IN_M) == '0) && ((pad_hiz & IN_M) == IN_M)); // R1

  AST_FIXED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_hiz & OUT_M) == '0); // R2

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> ((((pad_out ^ core_out) & DRV_M) == '0) &&
                    (((pad_hiz ^ core_hiz) & TS_M) == '0))); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !update) |=> (!test_mode || ($stable(pad_out) && $stable(pad_hiz)))); // R6

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> (tdo == $past(stage_q[1]))); // R7

endmodule

bind bscan_register bscan_register_chk #(
  .NUM_PINS  (NUM_PINS),
  .PIN_TYPES (PIN_TYPES),
  .NUM_CELLS (NUM_CELLS)
) u_chk (
  .clk       (tck),
  .rst_n     (trst_n),
  .test_mode (test_mode),
  .capture   (capture_dr),
  .shift     (shift_dr),
  .update    (update_dr),
  .tdo       (tdo),
  .stage_q   (stage_q),
  .core_out  (core_out),
  .core_hiz  (core_hiz),
  .pad_out   (pad_out),
  .pad_hiz   (pad_hiz)
);

// File: tb/bscan_register_test.sv
module bscan_register_test;

  localparam int NP = 8;
  // pin7..pin0 kinds: out, out_ts, in, bidir, out_ts, out, bidir, in
  localparam logic [2*NP-1:0] TYPES = {2'd1, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1, 2'd3, 2'd0};
  localparam int EXP_CELLS  = 14;   // 1+3+1+2+3+1+2+1
  localparam int FULL_CELLS = 246;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tm = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NP-1:0] pin_in = '0, core_out = '0, core_hiz = '0;
  logic [NP-1:0] pad_out, pad_hiz;

  logic f_sh = 1'b0, f_tdi = 1'b0, f_tdo;
  logic [191:0] f_zero = '0;
  logic [191:0] f_po, f_pz;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  string cur_tag = "R5";

  always #10 clk = ~clk;

  bscan_register #(.NUM_PINS(NP), .PIN_TYPES(TYPES)) uut (
    .tck(clk), .trst_n(rst_n), .test_mode(tm), .capture_dr(cap), .shift_dr(sh),
    .update_dr(upd), .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .core_out(core_out),
    .core_hiz(core_hiz), .pad_out(pad_out), .pad_hiz(pad_hiz));

  bscan_register uut_full (
    .tck(clk), .trst_n(rst_n), .test_mode(1'b0), .capture_dr(1'b0), .shift_dr(f_sh),
    .update_dr(1'b0), .tdi(f_tdi), .tdo(f_tdo), .pin_in(f_zero), .core_out(f_zero),
    .core_hiz(f_zero), .pad_out(f_po), .pad_hiz(f_pz));

  // ---- behavioural reference model ----
  int kind[NP];
  int base[NP];
  int ncell = 0;
  int cpin[32];
  int crole[32];   // 0 enable, 1 output, 2 input
  bit msh[32], mupd[32], nsh[32];

  task automatic add_cell(int p, int role);
    cpin[ncell] = p; crole[ncell] = role; ncell++;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      kind[p] = int'(TYPES[2*p +: 2]);
      base[p] = ncell;
      case (kind[p])
        0: add_cell(p, 2);
        1: add_cell(p, 1);
        2: begin add_cell(p, 0); add_cell(p, 1); end
        default: begin add_cell(p, 0); add_cell(p, 1); add_cell(p, 2); end
      endcase
    end
  end

  function automatic bit cap_val(int c);
    case (crole[c])
      0: return core_hiz[cpin[c]];
      1: return core_out[cpin[c]];
      default: return pin_in[cpin[c]];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 32; c++) begin msh[c] = 0; mupd[c] = (c < ncell) && (crole[c] == 0); end
    end else begin
      for (int c = 0; c < ncell; c++) begin
        if (cap)     nsh[c] = cap_val(c);
        else if (sh) nsh[c] = (c == ncell - 1) ? tdi : msh[c+1];
        else         nsh[c] = msh[c];
      end
      for (int c = 0; c < ncell; c++) begin
        if (upd) mupd[c] = msh[c];
        msh[c] = nsh[c];
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string kind_tag(int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare();
    bit eo, ez;
    chk({cur_tag, " R7 tdo"}, tdo, msh[0]);
    for (int p = 0; p < NP; p++) begin
      case (kind[p])
        0: begin eo = 0; ez = 1; end
        1: begin ez = 0; eo = tm ? mupd[base[p]] : core_out[p]; end
        default: begin
          ez = tm ? mupd[base[p]]   : core_hiz[p];
          eo = tm ? mupd[base[p]+1] : core_out[p];
        end
      endcase
      chk($sformatf("%s %s %s pad_out[%0d]", cur_tag, kind_tag(kind[p]), tm ? "R6" : "R5", p), pad_out[p], eo);
      chk($sformatf("%s %s %s pad_hiz[%0d]", cur_tag, kind_tag(kind[p]), tm ? "R6" : "R5", p), pad_hiz[p], ez);
    end
  endtask

  // drive one cycle's inputs at a negedge, then compare at the next negedge
  task automatic cyc(bit c, bit s, bit u, bit t, bit d);
    cap = c; sh = s; upd = u; tm = t; tdi = d;
    pin_in = NP'($urandom); core_out = NP'($urandom); core_hiz = NP'($urandom);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    #1 rst_n = 1'b0;
    tm = 1'b1;
    #5;
    // R10: reset state seen in test mode
    chk("R10 pad_hiz", pad_hiz, 8'b0111_1011);
    chk("R10 pad_out", pad_out, 8'h00);
    chk("R10 tdo", tdo, 1'b0);
    chk("R11 cell count", ncell, EXP_CELLS);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    compare();

    cur_tag = "R5";
    for (int i = 0; i < 20; i++) cyc($urandom % 2, $urandom % 2, $urandom % 2, 0, $urandom % 2);

    cur_tag = "R8";
    cyc(1, 0, 0, 1, 0);
    cur_tag = "R7";
    for (int i = 0; i < EXP_CELLS; i++) cyc(0, 1, 0, 1, $urandom % 2);
    cur_tag = "R6";
    cyc(0, 0, 1, 1, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0);
    cur_tag = "R8";
    cyc(1, 1, 0, 1, 1);
    cyc(0, 0, 0, 1, 0);
    cur_tag = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 1, $urandom % 2);
    cyc(1, 0, 1, 1, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 1, 1, 1, 1);
    cyc(0, 0, 0, 1, 0);

    cur_tag = "R6";
    for (int i = 0; i < 300; i++)
      cyc(($urandom % 4) == 0, $urandom % 2, ($urandom % 4) == 0, ($urandom % 8) != 0, $urandom % 2);

    // R11: marker travel through both chains after reset
    cur_tag = "R11";
    @(negedge clk) rst_n = 1'b0;
    cap = 0; upd = 0; tm = 1;
    @(negedge clk) rst_n = 1'b1;
    sh = 1; tdi = 1; f_sh = 1; f_tdi = 1;
    len = 0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      tdi = 0; f_tdi = 0;
      if (k <= EXP_CELLS) compare();
      if (tdo === 1'b1 && len == 0) len = -k;
      if (f_tdo === 1'b1) begin
        chk("R11 full chain length", k, FULL_CELLS);
        break;
      end
      if (k == 300) chk("R11 full chain length", k, FULL_CELLS);
    end
    chk("R11 test chain length", -len, EXP_CELLS);
    sh = 0; f_sh = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule